// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is an up-counter that runs from a fixed, undivided reference clock. Two level inputs control it. A run input lets it advance by one on every clock edge. A clear input forces it back to zero. When it is stopped, the count stays where it is, and only the clear input returns it to zero. The count is free-running and wraps from all ones to zero.

A programmable compare value sits alongside the counter. When the count steps onto that value, the block raises a single-cycle interrupt pulse. A compare value of zero disables the interrupt. The pulse fires only when the count changes into the compare value. A counter that sits on the compare value, or a compare value rewritten to equal a frozen count, does not produce another pulse. The control inputs are intended to come straight from register flops in a bus slave that lies outside this block.

The reset input asserts asynchronously. Its release is re-timed inside the block, so the counter leaves reset a fixed number of reference-clock edges after the reset input rises.

Top module: `cmp_match_timer`

## Requirements
- R1: While `rst_n` is low, `count_o` is zero and `irq_o` is low. After `rst_n` rises, the block stays in reset for `SYNC_STAGES` (default 2) further rising clock edges.
- R2: On each rising edge where `run_i` is 1 and `clear_i` is 0, `count_o` increases by exactly one.
- R3: On each rising edge where `run_i` is 0 and `clear_i` is 0, `count_o` keeps its value.
- R4: On each rising edge where `clear_i` is 1, `count_o` becomes zero, whatever the value of `run_i`.
- R5: The count is `WIDTH` bits wide (default 32). Stepping from all ones gives zero.
- R6: `irq_o` is high for the single clock cycle in which `count_o` first shows the value of `match_i` that was sampled at that same edge.
- R7: When `match_i` is zero, `irq_o` never rises.
- R8: The pulse does not repeat while the count stays on the compare value. Rewriting `match_i` to equal a frozen count gives no pulse.
- R9: The interrupt decision at each edge uses the value of `match_i` sampled at that edge. If the compare value keeps moving one step ahead of the count, a pulse follows on every step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Undivided reference clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| run_i | input | 1 | Count enable level |
| clear_i | input | 1 | Force-to-zero level, overrides run_i |
| match_i | input | WIDTH | Compare value, zero disables the interrupt |
| count_o | output | WIDTH | Present count |
| irq_o | output | 1 | Single-cycle compare pulse |

## Verification
Both results are registered, so `count_o` and `irq_o` reflect the inputs applied before an edge one edge later and change together. Each stimulus cycle is driven at the falling edge. The bench model computes the count and pulse expected after the following rising edge and queues them. A monitor pops one item one nanosecond after every rising edge and compares it. The first cycles after reset release are driven idle so that the `SYNC_STAGES`-edge release delay cannot shift any expected value.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  // What the counter register does on the coming edge.
  typedef enum logic [1:0] {
    CMT_HOLD = 2'd0,
    CMT_STEP = 2'd1,
    CMT_ZERO = 2'd2
  } cmt_cmd_e;

endpackage

// File: rtl/cmt_rst_sync.sv
module cmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_d = 1'b1;
    end else begin : g_many
      always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_ns = sr_q[STAGES-1];

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
  import cmt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmt_cmd_e         cmd,
  output logic [WIDTH-1:0] count_q,
  output logic [WIDTH-1:0] count_d
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic cnt_en;

  always_comb begin
    count_d = count_q;
    cnt_en  = 1'b0;
    case (cmd)
      CMT_STEP: begin
        count_d = count_q + ONE;
        cnt_en  = 1'b1;
      end
      CMT_ZERO: begin
        count_d = '0;
        cnt_en  = 1'b1;
      end
      default: begin
        count_d = count_q;
        cnt_en  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

endmodule

// File: rtl/cmt_match.sv
module cmt_match #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] count_q,
  input  logic [WIDTH-1:0] count_d,
  input  logic [WIDTH-1:0] match_i,
  output logic             irq_q
);

  logic armed;
  logic lands;
  logic moves;
  logic irq_d;

  always_comb begin
    armed = (match_i != '0);
    lands = (count_d == match_i);
    moves = (count_d != count_q);
    irq_d = armed && lands && moves;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

endmodule

// File: rtl/cmp_match_timer.sv
module cmp_match_timer
  import cmt_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] match_i,
  output logic [WIDTH-1:0] count_o,
  output logic             irq_o
);

  logic             rst_ns;
  cmt_cmd_e         cmd;
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;

  cmt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  // clear overrides run
  always_comb begin
    if (clear_i)    cmd = CMT_ZERO;
    else if (run_i) cmd = CMT_STEP;
    else            cmd = CMT_HOLD;
  end

  cmt_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_ns),
    .cmd     (cmd),
    .count_q (count_q),
    .count_d (count_d)
  );

  cmt_match #(.WIDTH(WIDTH)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_ns),
    .count_q (count_q),
    .count_d (count_d),
    .match_i (match_i),
    .irq_q   (irq_o)
  );

  assign count_o = count_q;

endmodule

// File: rtl/cmp_match_timer_chk.sv
module cmp_match_timer_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             run_i,
  input logic             clear_i,
  input logic [WIDTH-1:0] match_i,
  input logic [WIDTH-1:0] count_o,
  input logic             irq_o
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  // R2 R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (run_i && !clear_i) |=> (count_o == $past(count_o) + ONE));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!run_i && !clear_i) |=> $stable(count_o));

  // R4
  zero_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    clear_i |=> (count_o == '0));

  // R6
  hit_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_o |-> (count_o == $past(match_i)));

  // R7
  off_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_o |-> ($past(match_i) != '0));

  // R8
  moved_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_o |-> (count_o != $past(count_o)));

endmodule

bind cmp_match_timer cmp_match_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_ns  (rst_ns),
  .run_i   (run_i),
  .clear_i (clear_i),
  .match_i (match_i),
  .count_o (count_o),
  .irq_o   (irq_o)
);

// File: tb/test_cmp_match_timer.sv
`timescale 1ns/1ps
module test_cmp_match_timer;

  localparam int W = 10;
  localparam logic [W-1:0] TOP = '1;

  logic         clk;
  logic         rst_n;
  logic         run_i;
  logic         clear_i;
  logic [W-1:0] match_i;
  logic [W-1:0] count_o;
  logic         irq_o;

  int n_chk;
  int n_err;
  bit summed;

  logic [W-1:0] q_cnt[$];
  bit           q_irq[$];
  string        q_tag[$];
  logic [W-1:0] mdl;

  cmp_match_timer #(.WIDTH(W), .SYNC_STAGES(2)) i_cmp_match_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_i),
    .clear_i (clear_i),
    .match_i (match_i),
    .count_o (count_o),
    .irq_o   (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    if (!summed) begin
      summed = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
  endtask

  // Driver: one cycle of stimulus, expected result queued for next edge.
  task automatic step(input bit run, input bit clr, input logic [W-1:0] m, input string tag);
    logic [W-1:0] nxt;
    bit           pulse;
    @(negedge clk);
    run_i   = run;
    clear_i = clr;
    match_i = m;
    if (clr)      nxt = '0;
    else if (run) nxt = mdl + 1'b1;
    else          nxt = mdl;
    pulse = (m != '0) && (nxt == m) && (nxt != mdl);
    q_cnt.push_back(nxt);
    q_irq.push_back(pulse);
    q_tag.push_back(tag);
    mdl = nxt;
  endtask

  // Monitor
  always @(posedge clk) begin
    #1;
    if (q_cnt.size() > 0) begin
      logic [W-1:0] ec;
      bit           ei;
      string        tg;
      ec = q_cnt.pop_front();
      ei = q_irq.pop_front();
      tg = q_tag.pop_front();
      n_chk++;
      if (count_o !== ec) begin
        n_err++;
        $display("FAIL %s count: actual %0h expected %0h", tg, count_o, ec);
      end
      n_chk++;
      if (irq_o !== ei) begin
        n_err++;
        $display("FAIL %s irq: actual %0b expected %0b", tg, irq_o, ei);
      end
    end
  end

  initial begin
    #200000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0; summed = 1'b0; mdl = '0;
    rst_n = 1'b0; run_i = 1'b1; clear_i = 1'b0; match_i = 10'd1;
    repeat (4) @(negedge clk);
    // R1 reset state while run is high
    n_chk++;
    if (count_o !== '0 || irq_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1 reset: actual %0h/%0b expected 0/0", count_o, irq_o);
    end
    run_i = 1'b0;
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 10'd0, "R1");
    step(1'b0, 1'b1, 10'd0, "R4");
    // R2 R6: count up, pulse on reaching 5
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 10'd5, "R2_R6");
    // R3 hold
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 10'd5, "R3");
    // R8 compare rewritten to the frozen count
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 10'd8, "R8");
    // R4 clear beats run
    for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 10'd8, "R4");
    // R7 R5: compare zero across a full wrap
    for (int i = 0; i < 1030; i++) step(1'b1, 1'b0, 10'd0, (mdl == TOP) ? "R5" : "R7");
    // R9 compare two ahead then one ahead
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, mdl + 10'd2, "R9");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, mdl + 10'd1, "R9");
    // R6 pulse at all-ones
    while (mdl != TOP - 10'd2) step(1'b1, 1'b0, 10'd0, "R2");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, TOP, "R6");
    // R8 stop on compare value, no repeat
    step(1'b1, 1'b0, mdl + 10'd1, "R8");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, mdl, "R8");
    step(1'b0, 1'b1, mdl, "R4");
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule